// File: doc/BRIEF.md
# Two-Bucket Ingress Color Policer

This block meters the frames of a single traffic class against two token buckets, a committed one and an excess one, and gives each frame a color: green, yellow or red. Each accepted frame gets its color exactly one cycle later. The block only meters. Dropping frames or rewriting their headers is left to the logic that reads the color.

Tokens count either bytes or whole frames. Software turns the configured rate into a token increment per `tick` pulse. The committed bucket takes that increment first, and whatever it cannot hold spills into the excess bucket. Both bucket sizes are programmed in kilobytes in byte mode, or in frames in frame mode. The block can honour the color a frame already carries (aware) or ignore it (blind). When policing is switched off, every frame leaves with a programmed default color.

Top module: `class_token_policer`

## Requirements
- R1: After reset, `out_valid` is low and both buckets are full, so the first frames after reset see the whole committed and excess capacity.
- R2: Each cycle with `in_valid` high gives one cycle with `out_valid` high on the next clock, back-to-back frames included. Color codes are 0 green, 1 yellow and 2 red, and `out_color` never shows 3.
- R3: In byte mode (`cfg_unit_pkt`=0) a frame costs `in_len` tokens and each bucket holds its size field times 1024 tokens.
- R4: In frame mode (`cfg_unit_pkt`=1) a frame costs one token whatever its length, and each bucket holds its size field in tokens.
- R5: A frame that may use the committed bucket is green when that bucket holds at least its cost, and only the committed bucket is reduced.
- R6: A frame that does not fit the committed bucket but fits the excess bucket is yellow, and only the excess bucket is reduced.
- R7: A frame that fits neither bucket is red and consumes no tokens.
- R8: On each `tick` the committed bucket gains `cfg_rate_inc` tokens and saturates at its size. The surplus goes to the excess bucket, which saturates at its own size.
- R9: In aware mode a yellow input (code 1) may only be charged to the excess bucket, so it is yellow or red and never green.
- R10: In aware mode a red input (codes 2 and 3) leaves red and consumes no tokens.
- R11: In blind mode the incoming color has no effect on the verdict.
- R12: With `cfg_enable` low every frame leaves with `cfg_default_color` (code 3 read as red) and no tokens are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Policing on; when low, the default color is applied |
| cfg_unit_pkt | input | 1 | 1: tokens are frames, 0: tokens are bytes |
| cfg_aware | input | 1 | 1: honour the incoming color, 0: blind |
| cfg_default_color | input | 2 | Color given while policing is off |
| cfg_rate_inc | input | RATE_W | Tokens added per tick |
| cfg_commit_size | input | BURST_W | Committed bucket size (KB or frames) |
| cfg_excess_size | input | BURST_W | Excess bucket size (KB or frames) |
| tick | input | 1 | Refill strobe |
| in_valid | input | 1 | Frame present |
| in_len | input | LEN_W | Frame length in bytes |
| in_color | input | 2 | Incoming color |
| out_valid | output | 1 | Verdict strobe |
| out_color | output | 2 | Resulting color |

## Verification
The bench builds the block with LEN_W=12, BURST_W=8 and RATE_W=12. With these widths, a 1 KB byte-mode bucket (1024 tokens) sits inside the 12-bit length range. A single frame of 1024 bytes can therefore exactly empty the bucket, and a frame of 1025 bytes overshoots it, so both sides of the fit comparison are reachable.

Frame mode with buckets of two or three tokens lets short directed sequences walk through green, yellow and red and through the saturating spill of one tick into both buckets.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    CLR_GREEN  = 2'd0,
    CLR_YELLOW = 2'd1,
    CLR_RED    = 2'd2
  } color_e;

  // byte-mode bucket sizes are programmed in units of 1024 tokens
  localparam int KB_SHIFT = 10;
endpackage

// File: rtl/tp_bucket.sv
// One token bucket, stored as the deficit below full so reset means full.
module tp_bucket #(
  parameter int TOK_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TOK_W-1:0] size,
  input  logic [TOK_W-1:0] refill,
  input  logic             charge,
  input  logic [TOK_W-1:0] cost,
  output logic [TOK_W-1:0] level,
  output logic [TOK_W-1:0] overflow
);
  logic [TOK_W-1:0] deficit_q;
  logic [TOK_W-1:0] deficit_d;
  logic [TOK_W-1:0] after_refill;
  logic             deficit_en;

  always_comb begin
    level = (size > deficit_q) ? (size - deficit_q) : '0;
    if (refill > deficit_q) begin
      after_refill = '0;
      overflow     = refill - deficit_q;
    end else begin
      after_refill = deficit_q - refill;
      overflow     = '0;
    end
    deficit_d  = charge ? (after_refill + cost) : after_refill;
    deficit_en = charge | (refill != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deficit_q <= '0;
    end else if (deficit_en) begin
      deficit_q <= deficit_d;
    end
  end

  // R7
  charge_fits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    charge |-> (cost <= level));

  // R8
  refill_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!charge && refill != '0) |=> ((level >= $past(level)) || (size != $past(size))));
endmodule

// File: rtl/tp_verdict.sv
// Combinational color decision and bucket selection for one frame.
module tp_verdict #(
  parameter int LEN_W = 16,
  parameter int TOK_W = 26
) (
  input  logic             enable,
  input  logic             unit_pkt,
  input  logic             aware,
  input  logic [1:0]       default_color,
  input  logic             frame_valid,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [1:0]       frame_color,
  input  logic [TOK_W-1:0] level_c,
  input  logic [TOK_W-1:0] level_e,
  output logic [TOK_W-1:0] cost,
  output logic             charge_c,
  output logic             charge_e,
  output logic [1:0]       color
);
  import tp_pkg::*;

  logic   fit_c;
  logic   fit_e;
  color_e eff_in;
  color_e verdict;

  always_comb begin
    cost   = unit_pkt ? TOK_W'(1) : TOK_W'(frame_len);
    fit_c  = (level_c >= cost);
    fit_e  = (level_e >= cost);
    eff_in = CLR_GREEN;
    if (aware) begin
      case (frame_color)
        2'd0:    eff_in = CLR_GREEN;
        2'd1:    eff_in = CLR_YELLOW;
        default: eff_in = CLR_RED;
      endcase
    end

    charge_c = 1'b0;
    charge_e = 1'b0;
    verdict  = CLR_RED;
    if (!enable) begin
      case (default_color)
        2'd0:    verdict = CLR_GREEN;
        2'd1:    verdict = CLR_YELLOW;
        default: verdict = CLR_RED;
      endcase
    end else begin
      case (eff_in)
        CLR_GREEN: begin
          if (fit_c) begin
            verdict  = CLR_GREEN;
            charge_c = frame_valid;
          end else if (fit_e) begin
            verdict  = CLR_YELLOW;
            charge_e = frame_valid;
          end
        end
        CLR_YELLOW: begin
          if (fit_e) begin
            verdict  = CLR_YELLOW;
            charge_e = frame_valid;
          end
        end
        default: verdict = CLR_RED;
      endcase
    end
    color = verdict;
  end
endmodule

// File: rtl/class_token_policer.sv
module class_token_policer #(
  parameter int LEN_W   = 16,
  parameter int BURST_W = 16,
  parameter int RATE_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_unit_pkt,
  input  logic               cfg_aware,
  input  logic [1:0]         cfg_default_color,
  input  logic [RATE_W-1:0]  cfg_rate_inc,
  input  logic [BURST_W-1:0] cfg_commit_size,
  input  logic [BURST_W-1:0] cfg_excess_size,
  input  logic               tick,
  input  logic               in_valid,
  input  logic [LEN_W-1:0]   in_len,
  input  logic [1:0]         in_color,
  output logic               out_valid,
  output logic [1:0]         out_color
);
  import tp_pkg::*;

  localparam int TOK_W = BURST_W + KB_SHIFT;

  logic [TOK_W-1:0] size_c, size_e;
  logic [TOK_W-1:0] refill_c;
  logic [TOK_W-1:0] spill_c, spill_e;
  logic [TOK_W-1:0] level_c, level_e;
  logic [TOK_W-1:0] cost;
  logic             charge_c, charge_e;
  logic [1:0]       color_d;
  logic             valid_d;
  logic [1:0]       color_q;
  logic             valid_q;
  logic             color_en;

  always_comb begin
    if (cfg_unit_pkt) begin
      size_c = TOK_W'(cfg_commit_size);
      size_e = TOK_W'(cfg_excess_size);
    end else begin
      size_c = {cfg_commit_size, {KB_SHIFT{1'b0}}};
      size_e = {cfg_excess_size, {KB_SHIFT{1'b0}}};
    end
    refill_c = tick ? TOK_W'(cfg_rate_inc) : '0;
  end

  tp_verdict #(.LEN_W(LEN_W), .TOK_W(TOK_W)) verdict_i (
    .enable        (cfg_enable),
    .unit_pkt      (cfg_unit_pkt),
    .aware         (cfg_aware),
    .default_color (cfg_default_color),
    .frame_valid   (in_valid),
    .frame_len     (in_len),
    .frame_color   (in_color),
    .level_c       (level_c),
    .level_e       (level_e),
    .cost          (cost),
    .charge_c      (charge_c),
    .charge_e      (charge_e),
    .color         (color_d)
  );

  tp_bucket #(.TOK_W(TOK_W)) commit_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .size     (size_c),
    .refill   (refill_c),
    .charge   (charge_c),
    .cost     (cost),
    .level    (level_c),
    .overflow (spill_c)
  );

  tp_bucket #(.TOK_W(TOK_W)) excess_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .size     (size_e),
    .refill   (spill_c),
    .charge   (charge_e),
    .cost     (cost),
    .level    (level_e),
    .overflow (spill_e)
  );

  always_comb begin
    valid_d  = in_valid;
    color_en = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= 2'd0;
    end else if (color_en) begin
      color_q <= color_d;
    end
  end

  assign out_valid = valid_q;
  assign out_color = color_q;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  valid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2
  legal_color_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_color != 2'd3));

  // R9
  aware_yellow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_enable && cfg_aware && in_color == 2'd1) |=> (out_color != 2'd0));

  // R10
  aware_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && cfg_enable && cfg_aware && in_color[1]) |=> (out_color == 2'd2));

  // R12
  disabled_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_enable && cfg_default_color != 2'd3) |=> (out_color == $past(cfg_default_color)));
endmodule

// File: tb/class_token_policer_tb_top.sv
module class_token_policer_tb_top;
  localparam int LEN_W   = 12;
  localparam int BURST_W = 8;
  localparam int RATE_W  = 12;
  localparam logic [1:0] G = 2'd0;
  localparam logic [1:0] Y = 2'd1;
  localparam logic [1:0] R = 2'd2;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               cfg_enable, cfg_unit_pkt, cfg_aware;
  logic [1:0]         cfg_default_color;
  logic [RATE_W-1:0]  cfg_rate_inc;
  logic [BURST_W-1:0] cfg_commit_size, cfg_excess_size;
  logic               tick, in_valid;
  logic [LEN_W-1:0]   in_len;
  logic [1:0]         in_color;
  logic               out_valid;
  logic [1:0]         out_color;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  class_token_policer #(.LEN_W(LEN_W), .BURST_W(BURST_W), .RATE_W(RATE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_unit_pkt(cfg_unit_pkt),
    .cfg_aware(cfg_aware), .cfg_default_color(cfg_default_color),
    .cfg_rate_inc(cfg_rate_inc), .cfg_commit_size(cfg_commit_size),
    .cfg_excess_size(cfg_excess_size), .tick(tick), .in_valid(in_valid),
    .in_len(in_len), .in_color(in_color), .out_valid(out_valid), .out_color(out_color)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit pkt, input bit aware, input int csz, input int esz);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_enable = 1'b1; cfg_unit_pkt = pkt; cfg_aware = aware;
    cfg_default_color = G; cfg_rate_inc = '0;
    cfg_commit_size = BURST_W'(csz); cfg_excess_size = BURST_W'(esz);
    tick = 1'b0; in_valid = 1'b0; in_len = '0; in_color = G;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive one frame, sample its verdict one clock later
  task automatic frame(input int len, input logic [1:0] col, input logic [1:0] exp, input string tag);
    in_valid = 1'b1; in_len = LEN_W'(len); in_color = col;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, {tag, " valid"}, int'(out_valid), 1);
    check(out_color == exp, tag, int'(out_color), int'(exp));
    @(negedge clk);
  endtask

  task automatic pulse_tick(input int inc);
    cfg_rate_inc = RATE_W'(inc); tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_packet_basic;
    do_reset(1'b1, 1'b0, 3, 2);
    frame(4000, G, G, "R1 R4 R5 full commit 1");
    frame(1, G, G, "R4 R5 commit 2");
    frame(64, G, G, "R5 commit 3");
    frame(4000, G, Y, "R6 excess 1");
    frame(9, G, Y, "R6 excess 2");
    frame(9, G, R, "R7 both empty");
    frame(9, G, R, "R7 still empty");
  endtask

  task automatic t_refill;
    // continues from empty buckets of t_packet_basic
    pulse_tick(1);
    frame(5, G, G, "R8 one token refilled");
    frame(5, G, R, "R8 excess unaffected by small tick");
    pulse_tick(5);
    frame(5, G, G, "R8 spill a");
    frame(5, G, G, "R8 spill b");
    frame(5, G, G, "R8 spill c");
    frame(5, G, Y, "R8 spill to excess a");
    frame(5, G, Y, "R8 spill to excess b");
    frame(5, G, R, "R8 spill exhausted");
    pulse_tick(10);
    frame(5, G, G, "R8 saturate a");
    frame(5, G, G, "R8 saturate b");
    frame(5, G, G, "R8 saturate c");
    frame(5, G, Y, "R8 saturate excess a");
    frame(5, G, Y, "R8 saturate excess b");
    frame(5, G, R, "R8 saturation caps both");
  endtask

  task automatic t_bytes;
    do_reset(1'b0, 1'b0, 1, 1);
    frame(1025, G, R, "R3 over 1KB both buckets");
    frame(1024, G, G, "R3 R7 exact 1KB after red");
    do_reset(1'b0, 1'b0, 1, 1);
    frame(1000, G, G, "R3 1000 bytes");
    frame(24, G, G, "R3 remaining 24 bytes");
    frame(1, G, Y, "R3 R6 one byte to excess");
    frame(1024, G, R, "R3 excess short by one");
    frame(1023, G, Y, "R3 excess exact fit");
    frame(1, G, R, "R3 excess empty");
  endtask

  task automatic t_aware;
    do_reset(1'b1, 1'b1, 2, 1);
    frame(1, Y, Y, "R9 yellow input uses excess");
    frame(1, Y, R, "R9 yellow input not green");
    frame(1, R, R, "R10 red input");
    frame(1, 2'd3, R, "R10 code 3 input");
    frame(1, G, G, "R9 R10 commit intact a");
    frame(1, G, G, "R9 R10 commit intact b");
    frame(1, G, R, "R5 commit drained");
  endtask

  task automatic t_blind;
    do_reset(1'b1, 1'b0, 1, 1);
    frame(1, R, G, "R11 red input ignored");
    frame(1, Y, Y, "R11 yellow input follows buckets");
    frame(1, G, R, "R11 green input red when empty");
  endtask

  task automatic t_disable;
    do_reset(1'b1, 1'b0, 1, 0);
    cfg_enable = 1'b0; cfg_default_color = Y;
    for (int i = 0; i < 4; i++) frame(4000, 2'(i), Y, "R12 default yellow");
    cfg_default_color = R;
    frame(1, G, R, "R12 default red");
    cfg_default_color = 2'd3;
    frame(1, G, R, "R12 default code 3 as red");
    cfg_enable = 1'b1;
    frame(1, G, G, "R12 no tokens consumed");
    frame(1, G, R, "R12 commit now empty");
  endtask

  task automatic t_back_to_back;
    do_reset(1'b1, 1'b0, 2, 0);
    in_valid = 1'b1; in_len = 12'd7; in_color = G;
    @(negedge clk);
    check(out_valid && out_color == G, "R2 b2b first", int'(out_color), 0);
    @(negedge clk);
    check(out_valid && out_color == G, "R2 b2b second", int'(out_color), 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid && out_color == R, "R2 b2b third", int'(out_color), 2);
    @(negedge clk);
    check(out_valid == 1'b0, "R2 valid drops", int'(out_valid), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    t_packet_basic();
    t_refill();
    t_bytes();
    t_aware();
    t_blind();
    t_disable();
    t_back_to_back();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule